// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns the processor status register and the saved-state registers that surround interrupt handling. On each clock it executes one command from the surrounding core: take the pending interrupt, return from an exception, return from a given interrupt level, raise or lower the interrupt mask, wait for an interrupt, or load the status register. When an interrupt is accepted, the block saves the PC and, for levels above one, the status register into the per-level save slots. It then updates the status register and reports the vector that the fetch unit must jump to.

Level-one requests are not vectored by level. They are turned into one of three exceptions, user, kernel or double, according to the user-mode and exception-mode bits, and the cause register records a level-one code. Higher levels each have their own saved-PC and saved-status slot and their own vector, spaced at a fixed stride from a base address. After a wait command the block holds itself halted. It wakes by taking the first acceptable request, using the PC that follows the wait instruction as the saved return address.

Status register layout: bits [3:0] hold the interrupt level, bit 4 the exception-mode flag and bit 5 the user-mode flag. The other bits are carried unchanged. Commands (`cmd_i`): 0 none, 1 take, 2 return-from-exception, 3 return-from-level (level in `imm_i`), 4 set level (`imm_i`), 5 wait (`imm_i`), 6 load status register. Result kinds (`kind_o`): 0 none, 1 high-level entry, 2 user, 3 kernel, 4 double, 5 return, 6 illegal. Cause codes: 4 for a level-one interrupt, 0 for an illegal instruction.

Top module: `irq_seq`

## Requirements
- R1: After reset the status register reads 0x1F (0x10 when the interrupt option parameter is 0). Halted, redirect, kind, cause, old-status and all save slots read 0.
- R2: A take request changes no state and gives redirect 0 and kind 0 when any of these holds: the request level is not above the effective level, the level is above the level count, or the pending/enabled flag is low.
- R3: The effective level is the interrupt-level field. When exception mode is set it is instead the larger of that field and the EXCM_LEVEL parameter (3 by default), so a level equal to EXCM_LEVEL is rejected while exception mode is set.
- R4: Accepting level L>1 stores the entry PC in EPC slot L and the old status in EPS slot L. It sets the level field to L, sets exception mode, keeps the other bits, and redirects with kind 1 to HI_VEC_BASE+(L-2)*HI_VEC_STRIDE. The other slots are unchanged.
- R5: Accepting level 1 with exception mode clear stores the PC in EPC slot 1, sets cause to 4 and sets exception mode. It redirects to USER_VEC with kind 2 when user mode is set, or to KERNEL_VEC with kind 3 when it is clear.
- R6: Accepting level 1 with exception mode already set stores the PC in DEPC (in EPC slot 1 when HAS_DEPC is 0) and leaves EPC slot 1 unchanged. It sets cause to 4 and redirects to DOUBLE_VEC with kind 4.
- R7: Return-from-exception clears exception mode, keeps the other status bits and redirects to EPC slot 1 with kind 5.
- R8: Return-from-level n with 2 <= n <= level count loads the status register from EPS slot n and redirects to EPC slot n with kind 5.
- R9: Return-from-level with any other n sets cause to 0, reports kind 6 without redirect and leaves the status register unchanged.
- R10: Set-level puts the previous status on old_ps_o and writes imm_i into bits [3:0], keeping the other bits.
- R11: Wait does what set-level does and also sets halted. While halted, commands are ignored. The first acceptable request clears halted and performs entry on the next edge, saving the PC that followed the wait command instead of pc_i.
- R12: Load-status writes ps_wdata_i into the status register with no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| imm_i | input | 4 | Level operand of return, set-level and wait |
| pc_i | input | XLEN | PC of the current instruction |
| next_pc_i | input | XLEN | PC following the current instruction |
| ps_wdata_i | input | 32 | Value for load-status |
| pend_level_i | input | 4 | Highest pending level from the controller |
| pend_ok_i | input | 1 | Request still pending and enabled at that level |
| redirect_o | output | 1 | PC redirect valid, one cycle |
| pc_o | output | XLEN | Redirect target, held |
| kind_o | output | 3 | Result kind of the last command |
| ps_o | output | 32 | Status register |
| old_ps_o | output | 32 | Status before the last set-level or wait |
| cause_o | output | 6 | Cause register |
| epc_o | output | N_LEVELS*XLEN | EPC slots 1..N, slot n at [(n-1)*XLEN +: XLEN] |
| eps_o | output | (N_LEVELS-1)*32 | EPS slots 2..N, slot n at [(n-2)*32 +: 32] |
| depc_o | output | XLEN | Double-exception saved PC |
| halted_o | output | 1 | Waiting for an interrupt |

## Verification
Take requests are tried against a mask field of 15, against exception mode at a level equal to the exception-mode floor, with the enable flag low, and with a level above the count. This separates each rejection reason from a real entry. Level-one entry is tried with user mode set, with it clear, and, on a second instance whose floor is 0, with exception mode already set, so that the user, kernel and double paths each show their own vector and save slot. Nested entries at levels 4 and 6 followed by returns from 6, 4 and from out-of-range levels check that save slots do not interfere with each other and that illegal returns leave the status unchanged. A wait followed by ignored commands, a request that cannot be accepted and then an acceptable one shows that wake-up uses the saved following PC.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned PS_W    = 32;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned CAUSE_W = 6;
  localparam int unsigned EXCM_BIT = 4;
  localparam int unsigned UM_BIT   = 5;

  localparam logic [PS_W-1:0] EXCM_MASK = PS_W'(1) << EXCM_BIT;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_L1      = 6'd4;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_TAKE  = 3'd1,
    CMD_RFE   = 3'd2,
    CMD_RFI   = 3'd3,
    CMD_RSIL  = 3'd4,
    CMD_WAITI = 3'd5,
    CMD_WRPS  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_HIGH    = 3'd1,
    K_USER    = 3'd2,
    K_KERNEL  = 3'd3,
    K_DOUBLE  = 3'd4,
    K_RET     = 3'd5,
    K_ILLEGAL = 3'd6
  } kind_e;

  function automatic logic [PS_W-1:0] set_level(logic [PS_W-1:0] ps, logic [LVL_W-1:0] lvl);
    return {ps[PS_W-1:LVL_W], lvl};
  endfunction
endpackage

// File: rtl/irq_seq_gate.sv
module irq_seq_gate
  import irq_seq_pkg::*;
#(
  parameter int unsigned N_LEVELS   = 6,
  parameter int unsigned EXCM_LEVEL = 3
) (
  input  logic [LVL_W-1:0] cur_level_i,
  input  logic             excm_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             ok_i,
  output logic             take_o
);
  localparam logic [LVL_W-1:0] XLVL = LVL_W'(EXCM_LEVEL);
  localparam logic [LVL_W-1:0] NLVL = LVL_W'(N_LEVELS);

  logic [LVL_W-1:0] eff;

  always_comb begin
    eff = cur_level_i;
    if (excm_i && (XLVL > cur_level_i)) eff = XLVL;
  end

  assign take_o = ok_i && (level_i > eff) && (level_i <= NLVL);
endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec
  import irq_seq_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     N_LEVELS      = 6,
  parameter logic [XLEN-1:0] USER_VEC      = 'h340,
  parameter logic [XLEN-1:0] KERNEL_VEC    = 'h300,
  parameter logic [XLEN-1:0] DOUBLE_VEC    = 'h3c0,
  parameter logic [XLEN-1:0] HI_VEC_BASE   = 'h180,
  parameter logic [XLEN-1:0] HI_VEC_STRIDE = 'h40
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic             excm_i,
  input  logic             um_i,
  output kind_e            kind_o,
  output logic [XLEN-1:0]  vec_o
);
  logic [XLEN-1:0] tab [2:N_LEVELS];
  logic [XLEN-1:0] hi_vec;

  for (genvar l = 2; l <= N_LEVELS; l++) begin : g_tab
    assign tab[l] = HI_VEC_BASE + XLEN'(l - 2) * HI_VEC_STRIDE;
  end

  always_comb begin
    hi_vec = tab[2];
    for (int l = 2; l <= N_LEVELS; l++) begin
      if (level_i == LVL_W'(l)) hi_vec = tab[l];
    end
  end

  always_comb begin
    if (level_i > LVL_W'(1)) begin
      kind_o = K_HIGH;
      vec_o  = hi_vec;
    end else if (excm_i) begin
      kind_o = K_DOUBLE;
      vec_o  = DOUBLE_VEC;
    end else if (um_i) begin
      kind_o = K_USER;
      vec_o  = USER_VEC;
    end else begin
      kind_o = K_KERNEL;
      vec_o  = KERNEL_VEC;
    end
  end
endmodule

// File: rtl/irq_seq_bank.sv
module irq_seq_bank
  import irq_seq_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned N_LEVELS = 6,
  parameter bit          HAS_DEPC = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         epc_we_i,
  input  logic [LVL_W-1:0]             epc_sel_i,
  input  logic [XLEN-1:0]              epc_d_i,
  input  logic                         eps_we_i,
  input  logic [LVL_W-1:0]             eps_sel_i,
  input  logic [PS_W-1:0]              eps_d_i,
  input  logic                         depc_we_i,
  input  logic [XLEN-1:0]              depc_d_i,
  input  logic [LVL_W-1:0]             rd_sel_i,
  output logic [XLEN-1:0]              rd_epc_o,
  output logic [PS_W-1:0]              rd_eps_o,
  output logic [XLEN-1:0]              epc1_o,
  output logic [N_LEVELS*XLEN-1:0]     epc_flat_o,
  output logic [(N_LEVELS-1)*PS_W-1:0] eps_flat_o,
  output logic [XLEN-1:0]              depc_o
);
  logic [XLEN-1:0] epc_q [1:N_LEVELS];
  logic [PS_W-1:0] eps_q [2:N_LEVELS];

  for (genvar l = 1; l <= N_LEVELS; l++) begin : g_epc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) epc_q[l] <= '0;
      else if (epc_we_i && epc_sel_i == LVL_W'(l)) epc_q[l] <= epc_d_i;
    end
    assign epc_flat_o[(l-1)*XLEN +: XLEN] = epc_q[l];

    // R4
    epc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(epc_we_i && epc_sel_i == LVL_W'(l)) |=> $stable(epc_q[l]));
  end

  for (genvar l = 2; l <= N_LEVELS; l++) begin : g_eps
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) eps_q[l] <= '0;
      else if (eps_we_i && eps_sel_i == LVL_W'(l)) eps_q[l] <= eps_d_i;
    end
    assign eps_flat_o[(l-2)*PS_W +: PS_W] = eps_q[l];

    // R4
    eps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(eps_we_i && eps_sel_i == LVL_W'(l)) |=> $stable(eps_q[l]));
  end

  if (HAS_DEPC) begin : g_depc
    logic [XLEN-1:0] depc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) depc_q <= '0;
      else if (depc_we_i) depc_q <= depc_d_i;
    end
    assign depc_o = depc_q;
  end else begin : g_no_depc
    assign depc_o = '0;
  end

  always_comb begin
    rd_epc_o = '0;
    rd_eps_o = '0;
    for (int l = 1; l <= N_LEVELS; l++) begin
      if (rd_sel_i == LVL_W'(l)) rd_epc_o = epc_q[l];
    end
    for (int l = 2; l <= N_LEVELS; l++) begin
      if (rd_sel_i == LVL_W'(l)) rd_eps_o = eps_q[l];
    end
  end

  assign epc1_o = epc_q[1];
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     N_LEVELS      = 6,
  parameter int unsigned     EXCM_LEVEL    = 3,
  parameter bit              HAS_DEPC      = 1'b1,
  parameter bit              INT_OPT       = 1'b1,
  parameter logic [XLEN-1:0] USER_VEC      = 'h340,
  parameter logic [XLEN-1:0] KERNEL_VEC    = 'h300,
  parameter logic [XLEN-1:0] DOUBLE_VEC    = 'h3c0,
  parameter logic [XLEN-1:0] HI_VEC_BASE   = 'h180,
  parameter logic [XLEN-1:0] HI_VEC_STRIDE = 'h40
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   cmd_i,
  input  logic [3:0]                   imm_i,
  input  logic [XLEN-1:0]              pc_i,
  input  logic [XLEN-1:0]              next_pc_i,
  input  logic [31:0]                  ps_wdata_i,
  input  logic [3:0]                   pend_level_i,
  input  logic                         pend_ok_i,
  output logic                         redirect_o,
  output logic [XLEN-1:0]              pc_o,
  output logic [2:0]                   kind_o,
  output logic [31:0]                  ps_o,
  output logic [31:0]                  old_ps_o,
  output logic [5:0]                   cause_o,
  output logic [N_LEVELS*XLEN-1:0]     epc_o,
  output logic [(N_LEVELS-1)*32-1:0]   eps_o,
  output logic [XLEN-1:0]              depc_o,
  output logic                         halted_o
);
  localparam logic [PS_W-1:0]  PS_RST = INT_OPT ? 32'h1f : 32'h10;
  localparam logic [LVL_W-1:0] NLVL   = LVL_W'(N_LEVELS);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [PS_W-1:0]    ps_q, ps_d, old_ps_q, old_ps_d;
  logic               halted_q, halted_d, red_q, red_d;
  logic [XLEN-1:0]    wake_q, wake_d, pc_q, pc_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  kind_e              kind_q, kind_d;

  logic            take_ok, accept, rfi_ok;
  logic [XLEN-1:0] entry_pc, entry_vec;
  kind_e           entry_kind;

  logic                epc_we, eps_we, depc_we;
  logic [LVL_W-1:0]    epc_sel;
  logic [XLEN-1:0]     rd_epc, epc1;
  logic [PS_W-1:0]     rd_eps;

  irq_seq_gate #(.N_LEVELS(N_LEVELS), .EXCM_LEVEL(EXCM_LEVEL)) u_gate (
    .cur_level_i (ps_q[LVL_W-1:0]),
    .excm_i      (ps_q[EXCM_BIT]),
    .level_i     (pend_level_i),
    .ok_i        (pend_ok_i),
    .take_o      (take_ok)
  );

  irq_seq_vec #(
    .XLEN(XLEN), .N_LEVELS(N_LEVELS), .USER_VEC(USER_VEC), .KERNEL_VEC(KERNEL_VEC),
    .DOUBLE_VEC(DOUBLE_VEC), .HI_VEC_BASE(HI_VEC_BASE), .HI_VEC_STRIDE(HI_VEC_STRIDE)
  ) u_vec (
    .level_i (pend_level_i),
    .excm_i  (ps_q[EXCM_BIT]),
    .um_i    (ps_q[UM_BIT]),
    .kind_o  (entry_kind),
    .vec_o   (entry_vec)
  );

  irq_seq_bank #(.XLEN(XLEN), .N_LEVELS(N_LEVELS), .HAS_DEPC(HAS_DEPC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .epc_we_i   (epc_we),
    .epc_sel_i  (epc_sel),
    .epc_d_i    (entry_pc),
    .eps_we_i   (eps_we),
    .eps_sel_i  (pend_level_i),
    .eps_d_i    (ps_q),
    .depc_we_i  (depc_we),
    .depc_d_i   (entry_pc),
    .rd_sel_i   (imm_i),
    .rd_epc_o   (rd_epc),
    .rd_eps_o   (rd_eps),
    .epc1_o     (epc1),
    .epc_flat_o (epc_o),
    .eps_flat_o (eps_o),
    .depc_o     (depc_o)
  );

  // a halted core treats every cycle as a take request
  assign accept   = INT_OPT && take_ok && (halted_q || cmd == CMD_TAKE);
  assign entry_pc = halted_q ? wake_q : pc_i;
  assign rfi_ok   = (imm_i >= LVL_W'(2)) && (imm_i <= NLVL);

  always_comb begin
    ps_d     = ps_q;
    old_ps_d = old_ps_q;
    halted_d = halted_q;
    wake_d   = wake_q;
    cause_d  = cause_q;
    pc_d     = pc_q;
    red_d    = 1'b0;
    kind_d   = K_NONE;
    epc_we   = 1'b0;
    eps_we   = 1'b0;
    depc_we  = 1'b0;
    epc_sel  = pend_level_i;
    if (accept) begin
      halted_d = 1'b0;
      red_d    = 1'b1;
      pc_d     = entry_vec;
      kind_d   = entry_kind;
      if (pend_level_i > LVL_W'(1)) begin
        epc_we = 1'b1;
        eps_we = 1'b1;
        ps_d   = set_level(ps_q | EXCM_MASK, pend_level_i);
      end else begin
        epc_sel = LVL_W'(1);
        cause_d = CAUSE_L1;
        ps_d    = ps_q | EXCM_MASK;
        if (ps_q[EXCM_BIT] && HAS_DEPC) depc_we = 1'b1;
        else                            epc_we  = 1'b1;
      end
    end else if (!halted_q) begin
      unique case (cmd)
        CMD_RFE: begin
          ps_d   = ps_q & ~EXCM_MASK;
          pc_d   = epc1;
          red_d  = 1'b1;
          kind_d = K_RET;
        end
        CMD_RFI: begin
          if (rfi_ok) begin
            ps_d   = rd_eps;
            pc_d   = rd_epc;
            red_d  = 1'b1;
            kind_d = K_RET;
          end else begin
            cause_d = CAUSE_ILLEGAL;
            kind_d  = K_ILLEGAL;
          end
        end
        CMD_RSIL: begin
          old_ps_d = ps_q;
          ps_d     = set_level(ps_q, imm_i);
        end
        CMD_WAITI: begin
          old_ps_d = ps_q;
          ps_d     = set_level(ps_q, imm_i);
          halted_d = 1'b1;
          wake_d   = next_pc_i;
        end
        CMD_WRPS: ps_d = ps_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q     <= PS_RST;
      old_ps_q <= '0;
      halted_q <= 1'b0;
      wake_q   <= '0;
      cause_q  <= '0;
      pc_q     <= '0;
      red_q    <= 1'b0;
      kind_q   <= K_NONE;
    end else begin
      ps_q     <= ps_d;
      old_ps_q <= old_ps_d;
      halted_q <= halted_d;
      wake_q   <= wake_d;
      cause_q  <= cause_d;
      pc_q     <= pc_d;
      red_q    <= red_d;
      kind_q   <= kind_d;
    end
  end

  assign ps_o       = ps_q;
  assign old_ps_o   = old_ps_q;
  assign halted_o   = halted_q;
  assign cause_o    = cause_q;
  assign pc_o       = pc_q;
  assign redirect_o = red_q;
  assign kind_o     = kind_q;

  // R2
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_TAKE && !halted_q && !take_ok) |=> (!red_q && $stable(ps_q)));

  // R4
  hi_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_HIGH) |-> (ps_q[EXCM_BIT] && ps_q[LVL_W-1:0] == $past(pend_level_i)));

  // R5
  l1_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_USER || kind_q == K_KERNEL || kind_q == K_DOUBLE) |-> (ps_q[EXCM_BIT] && cause_q == CAUSE_L1));

  // R7
  rfe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RFE && !halted_q) |=> (!ps_q[EXCM_BIT] && red_q && pc_q == $past(epc1)));

  // R10
  rsil_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RSIL && !halted_q) |=> (ps_q[LVL_W-1:0] == $past(imm_i) && old_ps_q == $past(ps_q)));

  // R11
  halt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_q) |-> ($past(cmd) == CMD_WAITI));
endmodule

// File: tb/irq_seq_bench.sv
`timescale 1ns/1ps
module irq_seq_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  cmd_i = '0;
  logic [3:0]  imm_i = '0;
  logic [31:0] pc_i = '0, next_pc_i = '0, ps_wdata_i = '0;
  logic [3:0]  pend_level_i = '0;
  logic        pend_ok_i = 1'b0;

  logic        redirect_o, halted_o;
  logic [31:0] pc_o, ps_o, old_ps_o, depc_o;
  logic [2:0]  kind_o;
  logic [5:0]  cause_o;
  logic [191:0] epc_o;
  logic [159:0] eps_o;

  logic        d_red, d_halt;
  logic [31:0] d_pc, d_ps, d_old, d_depc;
  logic [2:0]  d_kind;
  logic [5:0]  d_cause;
  logic [191:0] d_epc;
  logic [159:0] d_eps;

  irq_seq u_irq_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .imm_i(imm_i), .pc_i(pc_i),
    .next_pc_i(next_pc_i), .ps_wdata_i(ps_wdata_i), .pend_level_i(pend_level_i),
    .pend_ok_i(pend_ok_i), .redirect_o(redirect_o), .pc_o(pc_o), .kind_o(kind_o),
    .ps_o(ps_o), .old_ps_o(old_ps_o), .cause_o(cause_o), .epc_o(epc_o),
    .eps_o(eps_o), .depc_o(depc_o), .halted_o(halted_o));

  // second instance with no exception-mode floor, to reach the double path
  irq_seq #(.EXCM_LEVEL(0)) u_irq_seq_dbl (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .imm_i(imm_i), .pc_i(pc_i),
    .next_pc_i(next_pc_i), .ps_wdata_i(ps_wdata_i), .pend_level_i(pend_level_i),
    .pend_ok_i(pend_ok_i), .redirect_o(d_red), .pc_o(d_pc), .kind_o(d_kind),
    .ps_o(d_ps), .old_ps_o(d_old), .cause_o(d_cause), .epc_o(d_epc),
    .eps_o(d_eps), .depc_o(d_depc), .halted_o(d_halt));

  typedef struct {
    string        tag;
    logic         red;
    logic [31:0]  pc;
    logic [2:0]   kind;
    logic [31:0]  ps;
    logic [31:0]  old;
    logic [5:0]   cause;
    logic         halt;
    logic [191:0] epc;
    logic [159:0] eps;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] m_ps = 32'h1f, m_old = '0, m_pc = '0, m_wake = '0;
  logic [5:0]  m_cause = '0;
  logic        m_halt = 1'b0;
  logic [31:0] m_epc [1:6];
  logic [31:0] m_eps [2:6];

  task automatic chk(string tag, string what, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [2:0] c, logic [3:0] im, logic [31:0] pc,
                      logic [31:0] npc, logic [31:0] wd, logic [3:0] lv, logic ok);
    exp_t it;
    logic [3:0] eff;
    logic acc;
    logic [31:0] ep;
    logic red;
    logic [2:0] kind;
    @(negedge clk);
    cmd_i = c; imm_i = im; pc_i = pc; next_pc_i = npc; ps_wdata_i = wd;
    pend_level_i = lv; pend_ok_i = ok;
    eff = (m_ps[4] && 4'd3 > m_ps[3:0]) ? 4'd3 : m_ps[3:0];
    acc = (m_halt || c == 3'd1) && ok && lv > eff && lv <= 4'd6;
    red = 1'b0; kind = 3'd0;
    if (acc) begin
      ep = m_halt ? m_wake : pc;
      m_halt = 1'b0; red = 1'b1;
      if (lv > 4'd1) begin
        m_epc[lv] = ep; m_eps[lv] = m_ps;
        m_ps = {m_ps[31:5], 1'b1, lv};
        m_pc = 32'h180 + 32'(lv - 4'd2) * 32'h40;
        kind = 3'd1;
      end else begin
        m_cause = 6'd4;
        m_epc[1] = ep;
        kind = m_ps[5] ? 3'd2 : 3'd3;
        m_pc = m_ps[5] ? 32'h340 : 32'h300;
        m_ps[4] = 1'b1;
      end
    end else if (!m_halt) begin
      case (c)
        3'd2: begin m_ps[4] = 1'b0; m_pc = m_epc[1]; red = 1'b1; kind = 3'd5; end
        3'd3: if (im >= 4'd2 && im <= 4'd6) begin
                m_ps = m_eps[im]; m_pc = m_epc[im]; red = 1'b1; kind = 3'd5;
              end else begin m_cause = 6'd0; kind = 3'd6; end
        3'd4: begin m_old = m_ps; m_ps[3:0] = im; end
        3'd5: begin m_old = m_ps; m_ps[3:0] = im; m_halt = 1'b1; m_wake = npc; end
        3'd6: m_ps = wd;
        default: ;
      endcase
    end
    it.tag = tag; it.red = red; it.pc = m_pc; it.kind = kind; it.ps = m_ps;
    it.old = m_old; it.cause = m_cause; it.halt = m_halt;
    for (int l = 1; l <= 6; l++) it.epc[(l-1)*32 +: 32] = m_epc[l];
    for (int l = 2; l <= 6; l++) it.eps[(l-2)*32 +: 32] = m_eps[l];
    q.push_back(it);
  endtask

  // monitor: outputs settle at the edge after the command
  always begin
    exp_t it;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, "redirect", 192'(redirect_o), 192'(it.red));
      chk(it.tag, "pc", 192'(pc_o), 192'(it.pc));
      chk(it.tag, "kind", 192'(kind_o), 192'(it.kind));
      chk(it.tag, "ps", 192'(ps_o), 192'(it.ps));
      chk(it.tag, "old_ps", 192'(old_ps_o), 192'(it.old));
      chk(it.tag, "cause", 192'(cause_o), 192'(it.cause));
      chk(it.tag, "halted", 192'(halted_o), 192'(it.halt));
      chk(it.tag, "epc", epc_o, it.epc);
      chk(it.tag, "eps", 192'(eps_o), 192'(it.eps));
      chk(it.tag, "depc", 192'(depc_o), 192'(0));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 1; l <= 6; l++) m_epc[l] = '0;
    for (int l = 2; l <= 6; l++) m_eps[l] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step("R1 reset", 3'd0, 4'd0, 0, 0, 0, 4'd0, 1'b0);
    step("R2 masked by field 15", 3'd1, 4'd0, 32'h100, 0, 0, 4'd4, 1'b1);
    step("R10 set level 0", 3'd4, 4'd0, 0, 0, 0, 4'd0, 1'b0);
    step("R6 level1 under excm", 3'd1, 4'd0, 32'h500, 0, 0, 4'd1, 1'b1);
    @(posedge clk); #1;
    chk("R6 double", "kind", 192'(d_kind), 192'(4));
    chk("R6 double", "pc", 192'(d_pc), 192'(32'h3c0));
    chk("R6 double", "depc", 192'(d_depc), 192'(32'h500));
    chk("R6 double", "epc1", 192'(d_epc[31:0]), 192'(0));
    chk("R6 double", "cause", 192'(d_cause), 192'(4));
    chk("R6 double", "ps", 192'(d_ps), 192'(32'h10));
    step("R3 level equal to floor", 3'd1, 4'd0, 32'h600, 0, 0, 4'd3, 1'b1);
    step("R4 entry level 4", 3'd1, 4'd0, 32'h1000, 0, 0, 4'd4, 1'b1);
    step("R2 enable low", 3'd1, 4'd0, 32'h1100, 0, 0, 4'd5, 1'b0);
    step("R2 above count", 3'd1, 4'd0, 32'h1200, 0, 0, 4'd7, 1'b1);
    step("R4 entry level 6", 3'd1, 4'd0, 32'h2000, 0, 0, 4'd6, 1'b1);
    step("R8 return level 6", 3'd3, 4'd6, 0, 0, 0, 4'd0, 1'b0);
    step("R9 return level 7", 3'd3, 4'd7, 0, 0, 0, 4'd0, 1'b0);
    step("R8 return level 4", 3'd3, 4'd4, 0, 0, 0, 4'd0, 1'b0);
    step("R12 load user mode", 3'd6, 4'd0, 0, 0, 32'h20, 4'd0, 1'b0);
    step("R5 user entry", 3'd1, 4'd0, 32'h3000, 0, 0, 4'd1, 1'b1);
    step("R9 return level 1", 3'd3, 4'd1, 0, 0, 0, 4'd0, 1'b0);
    step("R3 level1 under excm", 3'd1, 4'd0, 32'h3040, 0, 0, 4'd1, 1'b1);
    step("R7 return from exception", 3'd2, 4'd0, 0, 0, 0, 4'd0, 1'b0);
    step("R12 load kernel mode", 3'd6, 4'd0, 0, 0, 32'h0, 4'd0, 1'b0);
    step("R5 kernel entry", 3'd1, 4'd0, 32'h3100, 0, 0, 4'd1, 1'b1);
    step("R7 return kernel", 3'd2, 4'd0, 0, 0, 0, 4'd0, 1'b0);
    step("R11 wait level 2", 3'd5, 4'd2, 32'h4000, 32'h4004, 0, 4'd0, 1'b0);
    step("R11 load ignored", 3'd6, 4'd0, 0, 0, 32'hff, 4'd0, 1'b0);
    step("R11 request not above", 3'd0, 4'd0, 0, 0, 0, 4'd2, 1'b1);
    step("R11 wake level 5", 3'd0, 4'd0, 32'h9999, 0, 0, 4'd5, 1'b1);
    step("R8 return to wake pc", 3'd3, 4'd5, 0, 0, 0, 4'd0, 1'b0);
    step("R1 idle", 3'd0, 4'd0, 0, 0, 0, 4'd0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule